// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of an in-order pipeline. It compares the source register numbers of the instruction being decoded with the destination of the instruction currently in execute. If that execute instruction is a load and writes a register the decoder is about to read, forwarding cannot help: the loaded value does not exist yet. The unit then holds the program counter and the fetch/decode pipeline register for one cycle. In the same cycle it replaces the control word entering execute with a harmless bubble.

The outputs are combinational from the inputs of the current cycle, so the enables and the bubble select take effect at the next clock edge. A one-bit register remembers that a stall was just issued. This caps every stall at exactly one cycle, even if the inputs still show the hazard in the following cycle. Instructions two or more slots behind a load are left to forwarding and never stall. A load that targets register zero is ignored, because register zero is never really written.

Top module: `load_use_stall`

## Requirements
- R1: After reset, with no hazard on the inputs, `pc_we` and `ifid_we` are 1, `bubble_sel` is 0, and `idex_ctrl` equals `id_ctrl`.
- R2: When `ex_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a`, the unit stalls in that same cycle. A stall means `pc_we`=0, `ifid_we`=0 and `bubble_sel`=1. This holds unless the previous cycle was a stall.
- R3: The same stall happens when `ex_dst` equals `id_src_b` instead of `id_src_a`.
- R4: When `ex_load` is 0, no stall occurs, whatever the register numbers are.
- R5: When `ex_dst` is 0, no stall occurs, even if it matches a source and `ex_load` is 1.
- R6: A load whose `ex_dst` matches neither source causes no stall.
- R7: A stall never lasts more than one cycle. In the cycle after a stall the outputs show no stall, even if the hazard inputs are unchanged.
- R8: While `bubble_sel` is 1, `idex_ctrl` equals `id_ctrl` with every bit set in `KILL_MASK` cleared, and all other bits passed through. The default `KILL_MASK` is 8'h07: bit 0 is register write, bit 1 is memory read, bit 2 is memory write. While `bubble_sel` is 0, `idex_ctrl` equals `id_ctrl`.
- R9: After one cycle without a stall, a hazard present on the inputs stalls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_a | input | REG_IDX_W | First source register of the decode instruction |
| id_src_b | input | REG_IDX_W | Second source register of the decode instruction |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_IDX_W | Destination register of the execute-stage instruction |
| id_ctrl | input | CTRL_W | Control word produced by decode |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| bubble_sel | output | 1 | Selects the bubble control word into execute |
| idex_ctrl | output | CTRL_W | Control word delivered to the decode/execute register |

## Verification
The bench uses the default parameters: 5-bit register numbers, an 8-bit control word and kill mask 8'h07. These values put register zero, the all-ones register 31 and the control bits that are both inside and outside the mask within reach of directed vectors. Each scenario checks the stall outputs in the cycle the hazard inputs are applied. It then checks the following cycle to cover the one-cycle cap and the re-arming after it. Control words of all ones and of mixed bits show that the bubble clears exactly the masked bits.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int REG_IDX_W = 5,
  parameter int CTRL_W = 8,
  parameter logic [CTRL_W-1:0] KILL_MASK = 8'h07
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_IDX_W-1:0] id_src_a,
  input  logic [REG_IDX_W-1:0] id_src_b,
  input  logic                 ex_load,
  input  logic [REG_IDX_W-1:0] ex_dst,
  input  logic [CTRL_W-1:0]    id_ctrl,
  output logic                 pc_we,
  output logic                 ifid_we,
  output logic                 bubble_sel,
  output logic [CTRL_W-1:0]    idex_ctrl
);

  logic hit_a, hit_b, hazard, stall, stall_q;

  assign hit_a  = (ex_dst == id_src_a);
  assign hit_b  = (ex_dst == id_src_b);
  assign hazard = ex_load && (ex_dst != '0) && (hit_a || hit_b);
  assign stall  = hazard && !stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end

  assign pc_we      = !stall;
  assign ifid_we    = !stall;
  assign bubble_sel = stall;
  assign idex_ctrl  = stall ? (id_ctrl & ~KILL_MASK) : id_ctrl;

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> !bubble_sel && pc_we && ifid_we);

  a_r5_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> (pc_we && ifid_we && !bubble_sel));

  a_r4_not_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> (pc_we && ifid_we && !bubble_sel));

  a_r8_bubble_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> ((idex_ctrl & KILL_MASK) == '0) &&
                   ((idex_ctrl & ~KILL_MASK) == (id_ctrl & ~KILL_MASK)));

  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_sel |-> (idex_ctrl == id_ctrl));

endmodule

// File: tb/load_use_stall_tb.sv
module load_use_stall_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_src_a = '0, id_src_b = '0, ex_dst = '0;
  logic       ex_load = 1'b0;
  logic [7:0] id_ctrl = '0;
  logic       pc_we, ifid_we, bubble_sel;
  logic [7:0] idex_ctrl;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_use_stall u_dut (
    .clk(clk), .rst_n(rst_n), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_load(ex_load), .ex_dst(ex_dst), .id_ctrl(id_ctrl),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble_sel),
    .idex_ctrl(idex_ctrl)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic [4:0] dst,
                       input logic [4:0] a, input logic [4:0] b, input logic [7:0] c);
    @(negedge clk);
    ex_load = ld; ex_dst = dst; id_src_a = a; id_src_b = b; id_ctrl = c;
    #1;
  endtask

  task automatic expect_stall(input string tag, input logic s, input logic [7:0] ctrl_exp);
    chk({tag, " pc_we"}, {31'b0, pc_we}, {31'b0, !s});
    chk({tag, " ifid_we"}, {31'b0, ifid_we}, {31'b0, !s});
    chk({tag, " bubble_sel"}, {31'b0, bubble_sel}, {31'b0, s});
    chk({tag, " idex_ctrl"}, {24'b0, idex_ctrl}, {24'b0, ctrl_exp});
  endtask

  task automatic idle();
    drive(1'b0, 5'd0, 5'd0, 5'd0, 8'h00);
  endtask

  task automatic t_reset();
    drive(1'b0, 5'd3, 5'd3, 5'd4, 8'hA5);
    expect_stall("R1 reset", 1'b0, 8'hA5);
  endtask

  task automatic t_src_a();
    idle();
    drive(1'b1, 5'd7, 5'd7, 5'd9, 8'hFF);
    expect_stall("R2 match src_a", 1'b1, 8'hF8);
  endtask

  task automatic t_src_b();
    idle();
    drive(1'b1, 5'd31, 5'd1, 5'd31, 8'h5D);
    expect_stall("R3 match src_b", 1'b1, 8'h58);
  endtask

  task automatic t_not_load();
    idle();
    drive(1'b0, 5'd12, 5'd12, 5'd12, 8'hFF);
    expect_stall("R4 not a load", 1'b0, 8'hFF);
  endtask

  task automatic t_zero_dst();
    idle();
    drive(1'b1, 5'd0, 5'd0, 5'd0, 8'h07);
    expect_stall("R5 dst zero", 1'b0, 8'h07);
  endtask

  task automatic t_no_match();
    idle();
    drive(1'b1, 5'd6, 5'd5, 5'd14, 8'h3C);
    expect_stall("R6 no match", 1'b0, 8'h3C);
  endtask

  task automatic t_one_cycle();
    idle();
    drive(1'b1, 5'd2, 5'd2, 5'd2, 8'hFF);
    expect_stall("R7 first cycle", 1'b1, 8'hF8);
    drive(1'b1, 5'd2, 5'd2, 5'd2, 8'hFF);
    expect_stall("R7 held inputs", 1'b0, 8'hFF);
    drive(1'b1, 5'd2, 5'd2, 5'd2, 8'hFF);
    expect_stall("R9 rearmed", 1'b1, 8'hF8);
  endtask

  task automatic t_mask();
    idle();
    drive(1'b1, 5'd9, 5'd9, 5'd0, 8'h02);
    expect_stall("R8 mem read killed", 1'b1, 8'h00);
    idle();
    drive(1'b1, 5'd9, 5'd0, 5'd9, 8'hC4);
    expect_stall("R8 mem write killed", 1'b1, 8'hC0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_src_a();
    t_src_b();
    t_not_load();
    t_zero_dst();
    t_no_match();
    t_one_cycle();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule